// File: doc/BRIEF.md
# Dual 8-bit Timer with Pulse Generation

This block holds two 8-bit up-counters that draw their count enables from one shared free-running prescaler. A 2-bit mode field selects how the pair works. It can run as two separate interval timers. It can join the counters into one 16-bit timer. It can produce a programmable square wave that toggles on two compare points. It can also act as a fixed-period PWM generator whose compare value may be double-buffered. Each counter has its own compare register. Every match produces a single-cycle interrupt pulse, and it can also flip the timer output flip-flop that drives the output pin.

Software programs the block through a small synchronous write bus with four registers: control, clock select, compare 0 and compare 1. The timer output and the two interrupt pulses are registered. In interval mode, counter 1 can count counter 0's matches instead of a prescaler tap, so one pair of 8-bit counters can cover long intervals.

Top module: `dual_timer`

## Requirements
- R1: Register map. Address 0 is control: bits[1:0] hold the mode (00 two interval timers, 01 16-bit timer, 10 pulse generator, 11 PWM), bit2 is the counter 0 run bit, bit3 the counter 1 run bit, bit4 the output toggle enable, and bit5 the compare 0 buffer enable. Address 1 is clock select: bits[1:0] pick counter 0's enable (00 every cycle, 01 every 4th, 10 or 11 every 16th), and bits[3:2] pick counter 1's enable (00 counter 0 match, 01 every cycle, 10 every 16th, 11 every 256th). Address 2 is compare 0 and address 3 is compare 1. A write takes effect at the next clock edge.
- R2: Reset clears every register and counter, and holds tmr_out, irq0 and irq1 low.
- R3: In interval mode, a running counter that equals its compare value on a count enable clears to zero and pulses its interrupt for one cycle. With every-cycle counting, the pulses repeat every compare+1 cycles.
- R4: The 4 and 16 taps of counter 0 stretch its interval to 4*(compare0+1) and 16*(compare0+1) cycles.
- R5: Counter 1 can count counter 0 matches, which gives irq1 every (compare0+1)*(compare1+1) cycles. It can also use the 256 tap.
- R6: In interval mode, when the toggle enable is set, each counter 1 match inverts tmr_out. When the toggle enable is clear, tmr_out holds.
- R7: In 16-bit mode, counter 1 is the upper byte and {compare1, compare0} is the compare value. irq1 pulses every {compare1,compare0}+1 counts and irq0 stays low. Counter 0's run bit controls both bytes.
- R8: In pulse generator mode, tmr_out inverts when counter 0 equals compare 0 and again when it equals compare 1. Counter 0 clears on the compare 1 match. Software keeps compare 0 below compare 1.
- R9: In PWM mode, counter 0 wraps through 2^8 states. tmr_out rises on a compare 0 match (with irq0) and falls at the wrap (with irq1), so it is low for compare0+1 cycles and high for 255-compare0 cycles.
- R10: In PWM mode with the buffer enabled, a compare 0 write goes to a shadow register. That value moves into compare 0 only at the counter wrap.
- R11: A clear run bit holds its counter at zero and suppresses its matches. Once the run bit is set again, the first match comes after compare+1 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| tmr_out | output | 1 | Timer output flip-flop |
| irq0 | output | 1 | Counter 0 match pulse |
| irq1 | output | 1 | Counter 1, 16-bit or wrap pulse |

## Verification
The assertions assume that reset is held across at least one clock edge. They also assume that software keeps compare 0 below compare 1 in pulse generator mode; if it does not, the toggle pattern is no longer a clean two-phase wave. The stimulus applies a fresh reset before each scenario. It writes compare and clock-select values while the counters are stopped and then sets the mode and run bits in one control write. The only register written while a counter runs is the buffered compare in PWM mode, and the run bit in the stop-and-restart scenario.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_INT8  = 2'b00,
    MD_CAS16 = 2'b01,
    MD_PPG   = 2'b10,
    MD_PWM   = 2'b11
  } tmr_mode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CLK  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMP0 = 2'd2;
  localparam logic [ADDR_W-1:0] A_CMP1 = 2'd3;

  localparam int N_TAPS = 3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PRE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  output logic [N_TAPS-1:0] tap
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // taps fire once every 4, 16 and 256 cycles
  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int SH = 2 * (g + 1) + ((g == 2) ? 2 : 0);
    localparam logic [PRE_W-1:0] MSK = (PRE_W'(1) << SH) - PRE_W'(1);
    assign tap[g] = ((pre_q & MSK) == MSK);
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              pwm_wrap,
  output tmr_mode_e         mode,
  output logic              run0,
  output logic              run1,
  output logic              tgl,
  output logic              dbuf,
  output logic [1:0]        sel0,
  output logic [1:0]        sel1,
  output logic [CNT_W-1:0]  cmp0,
  output logic [CNT_W-1:0]  cmp1
);
  logic [CNT_W-1:0] shadow_q;
  logic             buffered;

  assign buffered = dbuf && (mode == MD_PWM);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MD_INT8;
      run0     <= 1'b0;
      run1     <= 1'b0;
      tgl      <= 1'b0;
      dbuf     <= 1'b0;
      sel0     <= 2'b00;
      sel1     <= 2'b00;
      cmp0     <= '0;
      cmp1     <= '0;
      shadow_q <= '0;
    end else begin
      if (pwm_wrap && dbuf) cmp0 <= shadow_q;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            mode <= tmr_mode_e'(wr_data[1:0]);
            run0 <= wr_data[2];
            run1 <= wr_data[3];
            tgl  <= wr_data[4];
            dbuf <= wr_data[5];
          end
          A_CLK: begin
            sel0 <= wr_data[1:0];
            sel1 <= wr_data[3:2];
          end
          A_CMP0: begin
            shadow_q <= wr_data;
            if (!buffered) cmp0 <= wr_data;
          end
          default: cmp1 <= wr_data;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_mode_e         mode,
  input  logic              run0,
  input  logic              run1,
  input  logic              tgl,
  input  logic [1:0]        sel0,
  input  logic [1:0]        sel1,
  input  logic [CNT_W-1:0]  cmp0,
  input  logic [CNT_W-1:0]  cmp1,
  input  logic [N_TAPS-1:0] tap,
  output logic              pwm_wrap,
  output logic              tmr_out,
  output logic              irq0,
  output logic              irq1
);
  logic [CNT_W-1:0] c0_q, c1_q;
  logic tick0, tick1, hit0, hit1, ppg_end, wide_hit, c0_full, casc;

  always_comb begin
    case (sel0)
      2'b00:   tick0 = 1'b1;
      2'b01:   tick0 = tap[0];
      default: tick0 = tap[1];
    endcase
    hit0     = (c0_q == cmp0);
    hit1     = (c1_q == cmp1);
    ppg_end  = (c0_q == cmp1);
    wide_hit = ({c1_q, c0_q} == {cmp1, cmp0});
    c0_full  = &c0_q;
    casc     = run0 && tick0 && hit0;
    case (sel1)
      2'b00:   tick1 = casc;
      2'b01:   tick1 = 1'b1;
      2'b10:   tick1 = tap[1];
      default: tick1 = tap[2];
    endcase
    pwm_wrap = (mode == MD_PWM) && run0 && tick0 && c0_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c0_q    <= '0;
      c1_q    <= '0;
      tmr_out <= 1'b0;
      irq0    <= 1'b0;
      irq1    <= 1'b0;
    end else begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
      unique case (mode)
        MD_INT8: begin
          if (!run0) c0_q <= '0;
          else if (tick0) begin
            if (hit0) begin
              c0_q <= '0;
              irq0 <= 1'b1;
            end else c0_q <= c0_q + 1'b1;
          end
          if (!run1) c1_q <= '0;
          else if (tick1) begin
            if (hit1) begin
              c1_q <= '0;
              irq1 <= 1'b1;
              if (tgl) tmr_out <= ~tmr_out;
            end else c1_q <= c1_q + 1'b1;
          end
        end
        MD_CAS16: begin
          if (!run0) {c1_q, c0_q} <= '0;
          else if (tick0) begin
            if (wide_hit) begin
              {c1_q, c0_q} <= '0;
              irq1 <= 1'b1;
              if (tgl) tmr_out <= ~tmr_out;
            end else {c1_q, c0_q} <= {c1_q, c0_q} + 1'b1;
          end
        end
        MD_PPG: begin
          c1_q <= '0;
          if (!run0) c0_q <= '0;
          else if (tick0) begin
            if (hit0) irq0 <= 1'b1;
            if (ppg_end) begin
              c0_q    <= '0;
              irq1    <= 1'b1;
              tmr_out <= ~tmr_out;
            end else begin
              c0_q <= c0_q + 1'b1;
              if (hit0) tmr_out <= ~tmr_out;
            end
          end
        end
        MD_PWM: begin
          c1_q <= '0;
          if (!run0) c0_q <= '0;
          else if (tick0) begin
            c0_q <= c0_q + 1'b1;
            if (hit0) irq0 <= 1'b1;
            if (c0_full) begin
              tmr_out <= 1'b0;
              irq1    <= 1'b1;
            end else if (hit0) tmr_out <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              tmr_out,
  output logic              irq0,
  output logic              irq1
);
  tmr_mode_e         mode_w;
  logic              run0_w, run1_w, tgl_w, dbuf_w, pwm_wrap_w;
  logic [1:0]        sel0_w, sel1_w;
  logic [CNT_W-1:0]  cmp0_w, cmp1_w;
  logic [N_TAPS-1:0] tap_w;

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tap(tap_w)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_wrap(pwm_wrap_w), .mode(mode_w), .run0(run0_w), .run1(run1_w),
    .tgl(tgl_w), .dbuf(dbuf_w), .sel0(sel0_w), .sel1(sel1_w),
    .cmp0(cmp0_w), .cmp1(cmp1_w)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .mode(mode_w), .run0(run0_w), .run1(run1_w),
    .tgl(tgl_w), .sel0(sel0_w), .sel1(sel1_w), .cmp0(cmp0_w), .cmp1(cmp1_w),
    .tap(tap_w), .pwm_wrap(pwm_wrap_w), .tmr_out(tmr_out), .irq0(irq0), .irq1(irq1)
  );
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input tmr_mode_e        mode,
  input logic             run0,
  input logic             run1,
  input logic             tgl,
  input logic             dbuf,
  input logic             pwm_wrap,
  input logic [CNT_W-1:0] cmp0,
  input logic             tmr_out,
  input logic             irq0,
  input logic             irq1
);
  // R2
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!tmr_out && !irq0 && !irq1));

  // R6
  tgl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode == MD_INT8 && !tgl)) |-> (tmr_out == $past(tmr_out)));

  // R7
  wide_irq0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode == MD_CAS16) |-> !irq0);

  // R8
  ppg_edge_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode == MD_PPG) && (tmr_out != $past(tmr_out))) |-> (irq0 || irq1));

  // R9
  pwm_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode == MD_PWM) && $rose(tmr_out)) |-> irq0);

  // R9
  pwm_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode == MD_PWM) && $fell(tmr_out)) |-> irq1);

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode == MD_PWM && dbuf && !pwm_wrap)) |-> (cmp0 == $past(cmp0)));

  // R11
  stop0_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!run0)) |-> !irq0);

  // R11
  stop1_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!run0 && !run1)) |-> !irq1);
endmodule

bind dual_timer dual_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_w), .run0(run0_w), .run1(run1_w), .tgl(tgl_w),
  .dbuf(dbuf_w), .pwm_wrap(pwm_wrap_w), .cmp0(cmp0_w), .tmr_out(tmr_out),
  .irq0(irq0), .irq1(irq1)
);

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tmr_out, irq0, irq1;

  dual_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_out(tmr_out), .irq0(irq0), .irq1(irq1)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    gap;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;
  int   errors = 0, checks = 0, cyc = 0, last_cyc = 0, watch = 0;
  int   irq0_cnt = 0, irq1_cnt = 0;
  bit   armed = 1'b0, seen_first = 1'b0;
  logic prev_out = 1'b0;
  logic ev;

  // monitor: pops one expected gap per observed event
  always @(negedge clk) begin
    cyc = cyc + 1;
    ev = (watch == 0) ? irq0 : (watch == 1) ? irq1 : (tmr_out != prev_out);
    prev_out = tmr_out;
    if (irq0) irq0_cnt = irq0_cnt + 1;
    if (irq1) irq1_cnt = irq1_cnt + 1;
    if (armed && ev) begin
      if (!seen_first) seen_first = 1'b1;
      else if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks = checks + 1;
        if (cyc - last_cyc != e.gap) begin
          errors = errors + 1;
          $display("FAIL %s: event gap actual=%0d expected=%0d", e.tag, cyc - last_cyc, e.gap);
        end
      end
      last_cyc = cyc;
    end
  end

  task automatic chk(input int act, input int expv, input string tag);
    checks = checks + 1;
    if (act != expv) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    armed = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_gaps(input int ga, input int gb, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t x;
      x.gap = (i % 2 == 0) ? ga : gb;
      x.tag = tag;
      exp_q.push_back(x);
    end
  endtask

  task automatic drain(input int limit, input string tag);
    int n = 0;
    while (exp_q.size() > 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    if (exp_q.size() > 0) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL %s: pending events actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
    end
    armed = 1'b0;
  endtask

  task automatic run_gaps(input int w, input int ga, input int gb, input int n,
                          input int limit, input string tag);
    push_gaps(ga, gb, n, tag);
    watch = w;
    seen_first = 1'b0;
    armed = 1'b1;
    drain(limit, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k;
    // R2: reset state
    repeat (3) @(negedge clk);
    chk(tmr_out, 0, "R2 out");
    chk(irq0, 0, "R2 irq0");
    chk(irq1, 0, "R2 irq1");
    rst = 1'b0;

    // R1 field encodings are used by every write below
    // R3: interval mode, every-cycle count, compare 7
    do_reset();
    wr(2'd2, 8'd7);
    wr(2'd0, 8'h04);
    run_gaps(0, 8, 8, 3, 200, "R3");

    // R4: divide-by-4 and divide-by-16 taps
    do_reset();
    wr(2'd2, 8'd5);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h04);
    run_gaps(0, 24, 24, 3, 400, "R4 div4");
    do_reset();
    wr(2'd2, 8'd2);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h04);
    run_gaps(0, 48, 48, 2, 400, "R4 div16");

    // R5: cascade and 256 tap
    do_reset();
    wr(2'd2, 8'd4);
    wr(2'd3, 8'd2);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0C);
    run_gaps(1, 15, 15, 3, 300, "R5 cascade");
    do_reset();
    wr(2'd3, 8'd1);
    wr(2'd1, 8'h0C);
    wr(2'd0, 8'h08);
    run_gaps(1, 512, 512, 2, 2500, "R5 div256");

    // R6: toggle on counter 1 match, and hold with toggle off
    do_reset();
    wr(2'd3, 8'd9);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h18);
    run_gaps(2, 10, 10, 4, 300, "R6 toggle");
    do_reset();
    wr(2'd3, 8'd3);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h08);
    irq1_cnt = 0;
    repeat (100) @(negedge clk);
    chk(tmr_out, 0, "R6 hold");
    chk(int'(irq1_cnt > 0), 1, "R6 counter running");

    // R7: 16-bit mode, compare 0x0102
    do_reset();
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h05);
    irq0_cnt = 0;
    run_gaps(1, 259, 259, 2, 1500, "R7");
    chk(irq0_cnt, 0, "R7 irq0 quiet");

    // R8: pulse generator, compares 20 and 50
    do_reset();
    wr(2'd2, 8'd20);
    wr(2'd3, 8'd50);
    wr(2'd0, 8'h06);
    run_gaps(2, 30, 21, 4, 400, "R8");

    // R9: PWM, compare 64
    do_reset();
    wr(2'd2, 8'd64);
    wr(2'd0, 8'h07);
    run_gaps(2, 191, 65, 4, 1500, "R9");

    // R10: buffered compare changes only at the wrap
    do_reset();
    wr(2'd2, 8'd64);
    wr(2'd0, 8'h27);
    exp_q.push_back('{191, "R10 old fall"});
    exp_q.push_back('{65,  "R10 old rise"});
    exp_q.push_back('{191, "R10 old fall"});
    exp_q.push_back('{33,  "R10 new rise"});
    exp_q.push_back('{223, "R10 new fall"});
    exp_q.push_back('{33,  "R10 new rise"});
    watch = 2;
    seen_first = 1'b0;
    armed = 1'b1;
    k = 0;
    while (exp_q.size() > 5 && k < 1000) begin
      @(negedge clk);
      k++;
    end
    repeat (10) @(negedge clk);
    wr(2'd2, 8'd32);
    drain(2000, "R10");

    // R11: stop holds counter at zero, restart counts from zero
    do_reset();
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h04);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    irq0_cnt = 0;
    repeat (50) @(negedge clk);
    chk(irq0_cnt, 0, "R11 stopped");
    wr(2'd0, 8'h04);
    k = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (irq0 && k == 0) k = i;
    end
    chk(k, 4, "R11 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule